// File: doc/BRIEF.md
# Power Button Event Handler

This block turns a raw, active-low push-button input into clean system requests. The input is synchronised and then filtered by a counter that advances on a slow tick. All actions come from the filtered level. When the filtered level goes from released to pressed, the block acts on the current power state:

- In the on state it raises a one-cycle SMI or SCI request, chosen by the enable bits.
- In a sleep state it raises a one-cycle wake request.
- In mechanical-off it does nothing at all.

A separate hold timer counts ticks while the button stays pressed. Counting starts only once the system is in the on state. When the timer completes, the block issues one unconditional power-down request.

A sleep-stretch flag comes from the sequencing logic. While it is set, presses cannot wake the system and the hold timer is kept cleared. The block also provides two status outputs: the filtered button level, and a sticky press status that is cleared by a write-one strobe. The actual power-state sequencing lies outside the block. With a 1 ms tick, the default parameters give a 16 ms filter and a 4 s hold.

Top module: `pbtn_event_unit`

## Requirements
- R1: The filtered level changes only after the synchronised input has differed from it on DEB_TICKS consecutive tick cycles. A press or release shorter than that is ignored entirely.
- R2: `btn_lvl_o` reads 1 while the filtered button is pressed and 0 while it is released.
- R3: With `pstate_i` = 0 (on), a filtered press with `btn_en_i` = 1 gives exactly one `sci_o` pulse if `sci_en_i` = 1. Otherwise it gives one `smi_o` pulse if `glb_smi_en_i` = 1, and no pulse in any other case. The request goes out one cycle after the filtered press.
- R4: With `pstate_i` in 1..5 (sleep) and `stretch_i` = 0, a filtered press gives exactly one `wake_o` pulse and never an SMI or SCI.
- R5: While `stretch_i` = 1, no `wake_o` or `ovr_o` pulse is issued, and the hold count restarts from zero.
- R6: With `pstate_i` = 6 or 7 (mechanical off), the filter is held cleared. `btn_lvl_o` reads 0, and no status or request is produced, however long the button is held.
- R7: `btn_sts_o` is set by every filtered press in states 0..5 and cleared by a one-cycle pulse on `sts_clr_i`. If both happen in the same cycle, the set wins.
- R8: A press held continuously for HOLD_TICKS ticks, counted from when the state is 0, produces one `ovr_o` pulse. A shorter hold produces none.
- R9: A hold that begins in sleep gives a wake pulse first. Hold counting begins only after `pstate_i` returns to 0, and it continues while the state stays within 0..4.
- R10: One continuous hold produces at most one `ovr_o` pulse, however long it lasts.
- R11: Releasing the button produces no request of any kind.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| tick_i | input | 1 | Slow time-base strobe, one cycle wide |
| btn_n_i | input | 1 | Raw button, low when pressed |
| pstate_i | input | 3 | Power state: 0 on, 1..5 sleep, 6..7 mechanical off |
| sci_en_i | input | 1 | Route button requests to SCI |
| btn_en_i | input | 1 | Button request enable in the on state |
| glb_smi_en_i | input | 1 | Global SMI enable |
| stretch_i | input | 1 | Minimum sleep-assertion stretch in progress |
| sts_clr_i | input | 1 | Write-one clear of the press status |
| smi_o | output | 1 | SMI request pulse |
| sci_o | output | 1 | SCI request pulse |
| wake_o | output | 1 | Wake request pulse |
| ovr_o | output | 1 | Unconditional power-down request pulse |
| btn_lvl_o | output | 1 | Filtered button level |
| btn_sts_o | output | 1 | Sticky press status |

## Verification
The checker watches several properties on every cycle:
- each request appears only in a state that permits it;
- a request coincides with a pressed level and never follows a release;
- stretch suppresses wake and override;
- mechanical-off keeps the level low;
- the level moves only in tick cycles;
- the override lasts a single cycle.

Some behaviour is visible only in whole press scenarios, so the bench covers it. This includes counting the filter and hold windows, rejecting short glitches, firing exactly one override per long hold, and deferring counting after a wake from sleep until the state returns to on.

// File: rtl/pbtn_pkg.sv
package pbtn_pkg;

    typedef enum logic [2:0] {
        PS_ON    = 3'd0,
        PS_SL1   = 3'd1,
        PS_SL2   = 3'd2,
        PS_SL3   = 3'd3,
        PS_SL4   = 3'd4,
        PS_SL5   = 3'd5,
        PS_OFF_A = 3'd6,
        PS_OFF_B = 3'd7
    } pstate_e;

    typedef struct packed {
        logic smi;
        logic sci;
        logic wake;
    } req_t;

    typedef struct packed {
        logic sci_en;
        logic btn_en;
        logic smi_en;
    } en_t;

    function automatic logic is_mech_off(input pstate_e ps);
        return (ps == PS_OFF_A) || (ps == PS_OFF_B);
    endfunction

    function automatic logic is_sleep(input pstate_e ps);
        return (ps != PS_ON) && !is_mech_off(ps);
    endfunction

    function automatic logic in_hold_zone(input pstate_e ps);
        return (ps <= PS_SL4);
    endfunction

    function automatic req_t route_press(input pstate_e ps, input en_t en,
                                         input logic stretch);
        req_t r;
        r = '0;
        if (ps == PS_ON) begin
            if (en.btn_en) begin
                if (en.sci_en)      r.sci = 1'b1;
                else if (en.smi_en) r.smi = 1'b1;
            end
        end else if (is_sleep(ps)) begin
            r.wake = !stretch;
        end
        return r;
    endfunction

endpackage

// File: rtl/pbtn_debounce.sv
module pbtn_debounce #(
    parameter int DEB_TICKS   = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk_i,
    input  logic rst_i,
    input  logic tick_i,
    input  logic raw_n_i,
    input  logic clear_i,
    output logic level_o,
    output logic rise_o
);
    localparam int CW = $clog2(DEB_TICKS + 1);
    localparam logic [CW-1:0] LAST = CW'(DEB_TICKS - 1);

    logic [SYNC_STAGES-1:0] sync_q;
    logic [CW-1:0]          cnt_q;
    logic                   stable_q;
    logic                   rise_q;
    logic                   sampled;

    assign sampled = sync_q[SYNC_STAGES-1];

    generate
        if (SYNC_STAGES == 1) begin : g_sync1
            always_ff @(posedge clk_i) begin
                if (rst_i || clear_i) sync_q <= '0;
                else                  sync_q <= ~raw_n_i;
            end
        end else begin : g_syncn
            always_ff @(posedge clk_i) begin
                if (rst_i || clear_i) sync_q <= '0;
                else                  sync_q <= {sync_q[SYNC_STAGES-2:0], ~raw_n_i};
            end
        end
    endgenerate

    always_ff @(posedge clk_i) begin
        if (rst_i || clear_i) begin
            cnt_q    <= '0;
            stable_q <= 1'b0;
            rise_q   <= 1'b0;
        end else begin
            rise_q <= 1'b0;
            if (sampled == stable_q) begin
                cnt_q <= '0;
            end else if (tick_i) begin
                if (cnt_q == LAST) begin
                    stable_q <= sampled;
                    rise_q   <= sampled;
                    cnt_q    <= '0;
                end else begin
                    cnt_q <= cnt_q + 1'b1;
                end
            end
        end
    end

    assign level_o = stable_q;
    assign rise_o  = rise_q;
endmodule

// File: rtl/pbtn_hold_timer.sv
module pbtn_hold_timer #(
    parameter int HOLD_TICKS = 4000
) (
    input  logic clk_i,
    input  logic rst_i,
    input  logic tick_i,
    input  logic level_i,
    input  logic in_on_i,
    input  logic in_zone_i,
    input  logic stretch_i,
    output logic ovr_o
);
    localparam int HW = $clog2(HOLD_TICKS + 1);
    localparam logic [HW-1:0] LAST = HW'(HOLD_TICKS - 1);

    logic [HW-1:0] cnt_q;
    logic          run_q;
    logic          fired_q;
    logic          ovr_q;

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            cnt_q   <= '0;
            run_q   <= 1'b0;
            fired_q <= 1'b0;
            ovr_q   <= 1'b0;
        end else begin
            ovr_q <= 1'b0;
            if (!level_i) begin
                run_q   <= 1'b0;
                cnt_q   <= '0;
                fired_q <= 1'b0;
            end else if (stretch_i || !in_zone_i) begin
                run_q <= 1'b0;
                cnt_q <= '0;
            end else if (!run_q) begin
                run_q <= in_on_i;
                cnt_q <= '0;
            end else if (tick_i && !fired_q) begin
                if (cnt_q == LAST) begin
                    ovr_q   <= 1'b1;
                    fired_q <= 1'b1;
                    cnt_q   <= '0;
                end else begin
                    cnt_q <= cnt_q + 1'b1;
                end
            end
        end
    end

    assign ovr_o = ovr_q;
endmodule

// File: rtl/pbtn_action.sv
module pbtn_action
    import pbtn_pkg::*;
(
    input  logic    clk_i,
    input  logic    rst_i,
    input  logic    rise_i,
    input  pstate_e ps_i,
    input  en_t     en_i,
    input  logic    stretch_i,
    input  logic    sts_clr_i,
    output req_t    req_o,
    output logic    sts_o
);
    req_t req_q;
    logic sts_q;

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            req_q <= '0;
            sts_q <= 1'b0;
        end else begin
            req_q <= '0;
            if (rise_i && !is_mech_off(ps_i)) begin
                req_q <= route_press(ps_i, en_i, stretch_i);
                sts_q <= 1'b1;
            end else if (sts_clr_i) begin
                sts_q <= 1'b0;
            end
        end
    end

    assign req_o = req_q;
    assign sts_o = sts_q;
endmodule

// File: rtl/pbtn_event_unit.sv
module pbtn_event_unit
    import pbtn_pkg::*;
#(
    parameter int DEB_TICKS   = 16,
    parameter int HOLD_TICKS  = 4000,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk_i,
    input  logic       rst_i,
    input  logic       tick_i,
    input  logic       btn_n_i,
    input  logic [2:0] pstate_i,
    input  logic       sci_en_i,
    input  logic       btn_en_i,
    input  logic       glb_smi_en_i,
    input  logic       stretch_i,
    input  logic       sts_clr_i,
    output logic       smi_o,
    output logic       sci_o,
    output logic       wake_o,
    output logic       ovr_o,
    output logic       btn_lvl_o,
    output logic       btn_sts_o
);
    pstate_e ps;
    en_t     en;
    logic    level;
    logic    rise;
    req_t    req;

    assign ps = pstate_e'(pstate_i);
    assign en = '{sci_en: sci_en_i, btn_en: btn_en_i, smi_en: glb_smi_en_i};

    pbtn_debounce #(.DEB_TICKS(DEB_TICKS), .SYNC_STAGES(SYNC_STAGES)) u_deb (
        .clk_i  (clk_i),
        .rst_i  (rst_i),
        .tick_i (tick_i),
        .raw_n_i(btn_n_i),
        .clear_i(is_mech_off(ps)),
        .level_o(level),
        .rise_o (rise)
    );

    pbtn_hold_timer #(.HOLD_TICKS(HOLD_TICKS)) u_hold (
        .clk_i    (clk_i),
        .rst_i    (rst_i),
        .tick_i   (tick_i),
        .level_i  (level),
        .in_on_i  (ps == PS_ON),
        .in_zone_i(in_hold_zone(ps)),
        .stretch_i(stretch_i),
        .ovr_o    (ovr_o)
    );

    pbtn_action u_act (
        .clk_i    (clk_i),
        .rst_i    (rst_i),
        .rise_i   (rise),
        .ps_i     (ps),
        .en_i     (en),
        .stretch_i(stretch_i),
        .sts_clr_i(sts_clr_i),
        .req_o    (req),
        .sts_o    (btn_sts_o)
    );

    assign smi_o     = req.smi;
    assign sci_o     = req.sci;
    assign wake_o    = req.wake;
    assign btn_lvl_o = level;
endmodule

// File: rtl/pbtn_event_unit_chk.sv
module pbtn_event_unit_chk (
    input logic       clk_i,
    input logic       rst_i,
    input logic       tick_i,
    input logic [2:0] pstate_i,
    input logic       stretch_i,
    input logic       smi_o,
    input logic       sci_o,
    input logic       wake_o,
    input logic       ovr_o,
    input logic       btn_lvl_o,
    input logic       btn_sts_o
);
    a_r1_level_moves_on_tick: assert property (@(posedge clk_i) disable iff (rst_i)
        (!$past(tick_i) && $past(pstate_i) < 3'd6) |-> $stable(btn_lvl_o));

    a_r3_cmd_only_when_on: assert property (@(posedge clk_i) disable iff (rst_i)
        (smi_o || sci_o) |-> ($past(pstate_i) == 3'd0 && !(smi_o && sci_o)));

    a_r4_wake_only_in_sleep: assert property (@(posedge clk_i) disable iff (rst_i)
        wake_o |-> ($past(pstate_i) >= 3'd1 && $past(pstate_i) <= 3'd5));

    a_r5_stretch_blocks: assert property (@(posedge clk_i) disable iff (rst_i)
        $past(stretch_i) |-> (!wake_o && !ovr_o));

    a_r6_mech_off_quiet: assert property (@(posedge clk_i) disable iff (rst_i)
        ($past(pstate_i) >= 3'd6) |-> (!btn_lvl_o && !smi_o && !sci_o && !wake_o));

    a_r7_sts_follows_request: assert property (@(posedge clk_i) disable iff (rst_i)
        (smi_o || sci_o || wake_o) |-> btn_sts_o);

    a_r8_ovr_in_zone: assert property (@(posedge clk_i) disable iff (rst_i)
        ovr_o |-> ($past(pstate_i) <= 3'd4 && btn_lvl_o));

    a_r10_ovr_single_cycle: assert property (@(posedge clk_i) disable iff (rst_i)
        ovr_o |=> !ovr_o);

    a_r11_no_request_on_release: assert property (@(posedge clk_i) disable iff (rst_i)
        (smi_o || sci_o || wake_o) |-> btn_lvl_o);
endmodule

bind pbtn_event_unit pbtn_event_unit_chk u_chk (
    .clk_i    (clk_i),
    .rst_i    (rst_i),
    .tick_i   (tick_i),
    .pstate_i (pstate_i),
    .stretch_i(stretch_i),
    .smi_o    (smi_o),
    .sci_o    (sci_o),
    .wake_o   (wake_o),
    .ovr_o    (ovr_o),
    .btn_lvl_o(btn_lvl_o),
    .btn_sts_o(btn_sts_o)
);

// File: tb/pbtn_event_unit_tb.sv
module pbtn_event_unit_tb;
    localparam int DEB  = 4;
    localparam int HOLD = 24;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic tick = 1'b0;
    logic btn_n = 1'b1;
    logic [2:0] pstate = 3'd0;
    logic sci_en = 1'b0, btn_en = 1'b0, smi_en = 1'b0, stretch = 1'b0, sts_clr = 1'b0;
    logic smi, sci, wake, ovr, lvl, sts;

    int checks = 0;
    int errors = 0;
    int n_smi = 0, n_sci = 0, n_wake = 0, n_ovr = 0;
    logic mon_clr = 1'b0;

    always #10 clk = ~clk;

    pbtn_event_unit #(.DEB_TICKS(DEB), .HOLD_TICKS(HOLD)) u_dut (
        .clk_i(clk), .rst_i(rst), .tick_i(tick), .btn_n_i(btn_n),
        .pstate_i(pstate), .sci_en_i(sci_en), .btn_en_i(btn_en),
        .glb_smi_en_i(smi_en), .stretch_i(stretch), .sts_clr_i(sts_clr),
        .smi_o(smi), .sci_o(sci), .wake_o(wake), .ovr_o(ovr),
        .btn_lvl_o(lvl), .btn_sts_o(sts)
    );

    always @(negedge clk) begin
        tick <= ~tick;
        if (mon_clr) begin
            n_smi <= 0; n_sci <= 0; n_wake <= 0; n_ovr <= 0;
        end else begin
            n_smi  <= n_smi  + int'(smi);
            n_sci  <= n_sci  + int'(sci);
            n_wake <= n_wake + int'(wake);
            n_ovr  <= n_ovr  + int'(ovr);
        end
    end

    typedef struct {int smi; int sci; int wake; int ovr; int sts; int lvl;} exp_t;

    function automatic exp_t expect_of(int ps, bit se, bit be, bit me, bit st, bit lng);
        exp_t e;
        e = '{0, 0, 0, 0, 0, 0};
        if (ps >= 6) return e;
        e.sts = 1; e.lvl = 1;
        if (ps == 0) begin
            e.sci = (be && se) ? 1 : 0;
            e.smi = (be && !se && me) ? 1 : 0;
            e.ovr = (lng && !st) ? 1 : 0;
        end else begin
            e.wake = st ? 0 : 1;
        end
        return e;
    endfunction

    task automatic check(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic cycles(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic clear_all();
        @(negedge clk); sts_clr = 1'b1; mon_clr = 1'b1;
        @(negedge clk); sts_clr = 1'b0; mon_clr = 1'b0;
    endtask

    task automatic trial(int ps, bit se, bit be, bit me, bit st, bit lng, string tag);
        exp_t e;
        e = expect_of(ps, se, be, me, st, lng);
        @(negedge clk);
        pstate = 3'(ps); sci_en = se; btn_en = be; smi_en = me; stretch = st;
        cycles(4);
        clear_all();
        btn_n = 1'b0;
        cycles(lng ? 110 : 20);
        check({tag, " R2 level while held"}, int'(lvl), e.lvl);
        btn_n = 1'b1;
        cycles(30);
        check({tag, " R2 level after release"}, int'(lvl), 0);
        check({tag, " R3 sci count"}, n_sci, e.sci);
        check({tag, " R3 smi count"}, n_smi, e.smi);
        check({tag, " R4 wake count"}, n_wake, e.wake);
        check({tag, " R8 ovr count"}, n_ovr, e.ovr);
        check({tag, " R7 status"}, int'(sts), e.sts);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        cycles(5);
        rst = 1'b0;
        cycles(1);
        check("reset outputs", int'({smi, sci, wake, ovr, lvl, sts}), 0);

        // R1: glitch shorter than the filter window
        pstate = 3'd0; btn_en = 1'b1; sci_en = 1'b1;
        clear_all();
        btn_n = 1'b0; cycles(5); btn_n = 1'b1; cycles(30);
        check("R1 glitch no sci", n_sci, 0);
        check("R1 glitch no status", int'(sts), 0);

        // R3/R11 directed: exactly one sci per press, none on release
        trial(0, 1, 1, 1, 0, 0, "dir_sci");
        trial(0, 0, 1, 1, 0, 0, "dir_smi");
        trial(0, 0, 0, 1, 0, 0, "dir_disabled");
        // R4/R5 sleep with and without stretch
        trial(3, 0, 1, 1, 0, 0, "dir_wake");
        trial(4, 0, 1, 1, 1, 1, "R5_stretch_sleep");
        trial(0, 1, 1, 1, 1, 1, "R5_stretch_on");
        // R6 mechanical off
        trial(6, 1, 1, 1, 0, 1, "R6_off6");
        trial(7, 1, 1, 1, 0, 0, "R6_off7");

        // R10: very long hold in the on state gives one override
        pstate = 3'd0; stretch = 1'b0; clear_all();
        btn_n = 1'b0; cycles(300); btn_n = 1'b1; cycles(30);
        check("R10 single override", n_ovr, 1);

        // R7: clear strobe drops status
        check("R7 status before clear", int'(sts), 1);
        @(negedge clk); sts_clr = 1'b1; @(negedge clk); sts_clr = 1'b0; cycles(1);
        check("R7 status after clear", int'(sts), 0);

        // R9: hold from sleep wakes first, counts only after return to on
        pstate = 3'd3; clear_all();
        btn_n = 1'b0; cycles(80);
        check("R9 wake from sleep", n_wake, 1);
        check("R9 no override while asleep", n_ovr, 0);
        pstate = 3'd0; cycles(40);
        check("R9 no override before window", n_ovr, 0);
        cycles(30);
        check("R9 override after window", n_ovr, 1);
        btn_n = 1'b1; cycles(30);
        check("R9 no command from sleep press", n_sci + n_smi, 0);

        // Random mix
        for (int i = 0; i < 40; i++) begin
            int ps;
            ps = int'($urandom_range(0, 7));
            trial(ps, 1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)),
                  1'($urandom_range(0, 1)), ($urandom_range(0, 3) == 0),
                  1'($urandom_range(0, 1)), "rand");
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule